// File: doc/BRIEF.md
# I2C SCL Phase Timer

This unit paces the clock line of an I2C master. It turns three packed 32-bit timing words into a repeating pattern of SCL low and high phases. It places a data-change strobe inside each low phase and a data-sample strobe inside each high phase. It also times two bus events: the hold interval that follows a START request, and the bus-free interval that follows a STOP.

The bit engine next to it requests a START and says, at the end of every high phase, whether the next step is a STOP or a clock stretch. It follows the strobes to drive and sample SDA. Every count advances only on cycles where the `tick` enable is high, so one configuration can run from any prescaled time base.

The unit does not compute timing from a bus speed. It uses the programmed counts as they are. The hardware adds a fixed latency to each phase: 2 ticks to the low phase and 7 ticks to the high phase.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted and after it is released with no request, scl_level is 1 and all four strobe outputs are 0.
- R2: Field layout. cfg_word0 bits 31:16 hold the high count and bits 15:0 hold the sample offset. cfg_word1 bits 31:16 hold the low count and bits 15:0 hold the change offset. cfg_word2 bits 31:16 hold the bus-free count and bits 15:0 hold the START lead-in count.
- R3: Each low phase drives scl_level to 0 for exactly (low count + 2) ticks.
- R4: Each high phase drives scl_level to 1 for exactly (high count + 7) ticks.
- R5: Only bits 9:0 of the high and low counts are used. Bits 15:10 of those fields have no effect.
- R6: change_stb is high for one cycle, in the cycle where the low-phase tick index (0 = first tick) first equals the change offset. It does not fire when the offset is (low count + 2) or more.
- R7: sample_stb is high for one cycle, in the cycle where the high-phase tick index first equals the sample offset. It does not fire when the offset is (high count + 7) or more.
- R8: start_req in the idle state starts a hold with scl_level at 1 that lasts max(lead-in, 1) ticks. The first low phase follows, and start_hold_done is high during its first cycle.
- R9: If stop_req is high when a high phase ends, scl_level stays 1 for max(bus-free, 1) ticks. The unit then returns to idle, and bus_free_done is high during the first idle cycle.
- R10: If stretch_req is high and stop_req is low when a high phase ends, scl_level stays 0 until stretch_req is seen low. A full low phase then starts. If both requests are high, stop_req wins.
- R11: Counters and phase ends advance only on cycles where tick is 1. With tick high every other cycle, every phase lasts twice as many cycles.
- R12: start_req is ignored outside idle. stop_req and stretch_req have no effect anywhere except at the end of a high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timing enable; counts advance only when high |
| cfg_word0 | input | 32 | High count and sample offset |
| cfg_word1 | input | 32 | Low count and change offset |
| cfg_word2 | input | 32 | Bus-free count and START lead-in count |
| start_req | input | 1 | Begin a START hold from idle |
| stop_req | input | 1 | At the end of a high phase, go to bus-free |
| stretch_req | input | 1 | At the end of a high phase, hold SCL low |
| scl_level | output | 1 | SCL level requested by the timer |
| sample_stb | output | 1 | One-cycle SDA sample point in the high phase |
| change_stb | output | 1 | One-cycle SDA change point in the low phase |
| start_hold_done | output | 1 | START hold finished; first cycle of the first low phase |
| bus_free_done | output | 1 | Bus-free interval finished; first idle cycle |

## Verification
The hardest case to reach from the ports is a clock stretch that lands on the last bit of a frame. There stop_req and stretch_req are both high at the same phase end, and the unit must choose bus-free.

The random frames pick the stretched bit from the whole frame, so the stretch sometimes falls on the final bit and exercises this priority. Offsets are drawn a few values past the phase length, so the strobe-suppression boundary is also hit. A directed run toggles tick every cycle to stretch every phase.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

    localparam int TG_WORD_W     = 32;
    localparam int TG_PHASE_W    = 10;
    localparam int TG_LOW_EXTRA  = 2;
    localparam int TG_HIGH_EXTRA = 7;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LEAD    = 3'd1,
        ST_LOW     = 3'd2,
        ST_HIGH    = 3'd3,
        ST_HOLDLOW = 3'd4,
        ST_FREE    = 3'd5
    } tg_state_e;

endpackage

// File: rtl/scl_tg_cfg.sv
module scl_tg_cfg #(
    parameter int WORD_W     = scl_tg_pkg::TG_WORD_W,
    parameter int PHASE_W    = scl_tg_pkg::TG_PHASE_W,
    parameter int LOW_EXTRA  = scl_tg_pkg::TG_LOW_EXTRA,
    parameter int HIGH_EXTRA = scl_tg_pkg::TG_HIGH_EXTRA,
    localparam int HALF_W    = WORD_W / 2
) (
    input  logic [WORD_W-1:0] word_hi,
    input  logic [WORD_W-1:0] word_lo,
    input  logic [WORD_W-1:0] word_bus,
    output logic [HALF_W-1:0] high_last,
    output logic [HALF_W-1:0] low_last,
    output logic [HALF_W-1:0] smp_off,
    output logic [HALF_W-1:0] chg_off,
    output logic [HALF_W-1:0] lead_last,
    output logic [HALF_W-1:0] free_last
);

    logic [HALF_W-1:0] high_raw;
    logic [HALF_W-1:0] low_raw;
    logic [HALF_W-1:0] high_eff;
    logic [HALF_W-1:0] low_eff;
    logic [HALF_W-1:0] lead_raw;
    logic [HALF_W-1:0] free_raw;

    assign high_raw = word_hi[WORD_W-1:HALF_W];
    assign smp_off  = word_hi[HALF_W-1:0];
    assign low_raw  = word_lo[WORD_W-1:HALF_W];
    assign chg_off  = word_lo[HALF_W-1:0];
    assign free_raw = word_bus[WORD_W-1:HALF_W];
    assign lead_raw = word_bus[HALF_W-1:0];

    // Phase counts keep only their low PHASE_W bits.
    generate
        if (PHASE_W < HALF_W) begin : g_mask
            localparam logic [HALF_W-1:0] PHASE_MASK = HALF_W'((1 << PHASE_W) - 1);
            assign high_eff = high_raw & PHASE_MASK;
            assign low_eff  = low_raw & PHASE_MASK;
        end else begin : g_full
            assign high_eff = high_raw;
            assign low_eff  = low_raw;
        end
    endgenerate

    // Last counter value of each interval (counter starts at zero).
    assign high_last = high_eff + HALF_W'(HIGH_EXTRA - 1);
    assign low_last  = low_eff + HALF_W'(LOW_EXTRA - 1);
    assign lead_last = (lead_raw == '0) ? '0 : lead_raw - HALF_W'(1);
    assign free_last = (free_raw == '0) ? '0 : free_raw - HALF_W'(1);

endmodule

// File: rtl/scl_tg_core.sv
module scl_tg_core
    import scl_tg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             stretch_req,
    input  logic [CNT_W-1:0] high_last,
    input  logic [CNT_W-1:0] low_last,
    input  logic [CNT_W-1:0] lead_last,
    input  logic [CNT_W-1:0] free_last,
    output tg_state_e        st_q,
    output tg_state_e        st_d,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             scl_level,
    output logic             hold_done,
    output logic             free_done
);

    typedef struct packed {
        tg_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             scl;
        logic             hold_done;
        logic             free_done;
    } core_t;

    core_t r_q;
    core_t r_d;

    always_comb begin
        r_d           = r_q;
        r_d.hold_done = 1'b0;
        r_d.free_done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_req) begin
                    r_d.st  = ST_LEAD;
                    r_d.cnt = '0;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    if (r_q.cnt >= lead_last) begin
                        r_d.st        = ST_LOW;
                        r_d.cnt       = '0;
                        r_d.hold_done = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_LOW: begin
                if (tick) begin
                    if (r_q.cnt >= low_last) begin
                        r_d.st  = ST_HIGH;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (r_q.cnt >= high_last) begin
                        r_d.cnt = '0;
                        if (stop_req) begin
                            r_d.st = ST_FREE;
                        end else if (stretch_req) begin
                            r_d.st = ST_HOLDLOW;
                        end else begin
                            r_d.st = ST_LOW;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_HOLDLOW: begin
                if (!stretch_req) begin
                    r_d.st  = ST_LOW;
                    r_d.cnt = '0;
                end
            end
            ST_FREE: begin
                if (tick) begin
                    if (r_q.cnt >= free_last) begin
                        r_d.st        = ST_IDLE;
                        r_d.cnt       = '0;
                        r_d.free_done = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.cnt = '0;
            end
        endcase
        r_d.scl = !((r_d.st == ST_LOW) || (r_d.st == ST_HOLDLOW));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, scl: 1'b1, hold_done: 1'b0, free_done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign st_q      = r_q.st;
    assign st_d      = r_d.st;
    assign cnt_q     = r_q.cnt;
    assign cnt_d     = r_d.cnt;
    assign scl_level = r_q.scl;
    assign hold_done = r_q.hold_done;
    assign free_done = r_q.free_done;

endmodule

// File: rtl/scl_tg_strobe.sv
module scl_tg_strobe
    import scl_tg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tg_state_e        st_q,
    input  tg_state_e        st_d,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic [CNT_W-1:0] chg_off,
    input  logic [CNT_W-1:0] smp_off,
    output logic             change_stb,
    output logic             sample_stb
);

    localparam int NLANE = 2;   // lane 0: change in low, lane 1: sample in high

    logic [NLANE-1:0] stb_d;
    logic [NLANE-1:0] stb_q;
    logic             counter_moved;

    // A strobe fires only on the cycle the counter first holds its offset.
    assign counter_moved = (st_d != st_q) || (cnt_d != cnt_q);

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane
            localparam tg_state_e LANE_ST = (g == 0) ? ST_LOW : ST_HIGH;
            logic [CNT_W-1:0] off;
            assign off = (g == 0) ? chg_off : smp_off;
            always_comb begin
                stb_d[g] = counter_moved && (st_d == LANE_ST) && (cnt_d == off);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q <= '0;
        end else begin
            stb_q <= stb_d;
        end
    end

    assign change_stb = stb_q[0];
    assign sample_stb = stb_q[1];

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tg_pkg::*;
#(
    parameter int WORD_W     = TG_WORD_W,
    parameter int PHASE_W    = TG_PHASE_W,
    parameter int LOW_EXTRA  = TG_LOW_EXTRA,
    parameter int HIGH_EXTRA = TG_HIGH_EXTRA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [WORD_W-1:0] cfg_word0,
    input  logic [WORD_W-1:0] cfg_word1,
    input  logic [WORD_W-1:0] cfg_word2,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              stretch_req,
    output logic              scl_level,
    output logic              sample_stb,
    output logic              change_stb,
    output logic              start_hold_done,
    output logic              bus_free_done
);

    localparam int HALF_W = WORD_W / 2;

    logic [HALF_W-1:0] high_last;
    logic [HALF_W-1:0] low_last;
    logic [HALF_W-1:0] smp_off;
    logic [HALF_W-1:0] chg_off;
    logic [HALF_W-1:0] lead_last;
    logic [HALF_W-1:0] free_last;
    tg_state_e         core_st_q;
    tg_state_e         core_st_d;
    logic [HALF_W-1:0] core_cnt_q;
    logic [HALF_W-1:0] core_cnt_d;

    scl_tg_cfg #(
        .WORD_W     (WORD_W),
        .PHASE_W    (PHASE_W),
        .LOW_EXTRA  (LOW_EXTRA),
        .HIGH_EXTRA (HIGH_EXTRA)
    ) u_cfg (
        .word_hi   (cfg_word0),
        .word_lo   (cfg_word1),
        .word_bus  (cfg_word2),
        .high_last (high_last),
        .low_last  (low_last),
        .smp_off   (smp_off),
        .chg_off   (chg_off),
        .lead_last (lead_last),
        .free_last (free_last)
    );

    scl_tg_core #(
        .CNT_W (HALF_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .start_req   (start_req),
        .stop_req    (stop_req),
        .stretch_req (stretch_req),
        .high_last   (high_last),
        .low_last    (low_last),
        .lead_last   (lead_last),
        .free_last   (free_last),
        .st_q        (core_st_q),
        .st_d        (core_st_d),
        .cnt_q       (core_cnt_q),
        .cnt_d       (core_cnt_d),
        .scl_level   (scl_level),
        .hold_done   (start_hold_done),
        .free_done   (bus_free_done)
    );

    scl_tg_strobe #(
        .CNT_W (HALF_W)
    ) u_stb (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_q       (core_st_q),
        .st_d       (core_st_d),
        .cnt_q      (core_cnt_q),
        .cnt_d      (core_cnt_d),
        .chg_off    (chg_off),
        .smp_off    (smp_off),
        .change_stb (change_stb),
        .sample_stb (sample_stb)
    );

endmodule

// File: rtl/scl_tg_checker.sv
module scl_tg_checker
    import scl_tg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             stretch_req,
    input logic             scl_level,
    input logic             sample_stb,
    input logic             change_stb,
    input logic             start_hold_done,
    input logic             bus_free_done,
    input tg_state_e        st_q,
    input logic [CNT_W-1:0] cnt_q
);

    // R6: the change point lies in a low phase and lasts one cycle
    a_r6_change_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        change_stb |-> !scl_level);
    a_r6_change_single: assert property (@(posedge clk) disable iff (!rst_n)
        change_stb |=> !change_stb);

    // R7: the sample point lies in a high phase and lasts one cycle
    a_r7_sample_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> scl_level);
    a_r7_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    // R8: the hold-done pulse marks the first falling SCL
    a_r8_hold_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        start_hold_done |-> (!scl_level && $past(scl_level)));

    // R9: the bus-free pulse arrives with SCL released
    a_r9_free_done_high: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free_done |-> (scl_level && $past(scl_level)));

    // R10: releasing the stretch starts a fresh low phase
    a_r10_stretch_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLDLOW && !stretch_req) |=> (st_q == ST_LOW && cnt_q == '0));

    // R11: timed states freeze when tick is low
    a_r11_freeze_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && (st_q == ST_LEAD || st_q == ST_LOW || st_q == ST_HIGH || st_q == ST_FREE))
        |=> ($stable(cnt_q) && $stable(st_q)));

    // R5: the low-phase counter never passes the 10-bit count plus latency
    a_r5_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOW) |-> (cnt_q <= CNT_W'(1025)));

endmodule

bind scl_timing_gen scl_tg_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick            (tick),
    .stretch_req     (stretch_req),
    .scl_level       (scl_level),
    .sample_stb      (sample_stb),
    .change_stb      (change_stb),
    .start_hold_done (start_hold_done),
    .bus_free_done   (bus_free_done),
    .st_q            (core_st_q),
    .cnt_q           (core_cnt_q)
);

// File: tb/sim_scl_timing_gen.sv
`timescale 1ns/1ps
module sim_scl_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        tick_mode = 1'b0;
    logic [31:0] w0 = '0;
    logic [31:0] w1 = '0;
    logic [31:0] w2 = '0;
    logic        start_req = 1'b0;
    logic        stop_req = 1'b0;
    logic        stretch_req = 1'b0;
    logic        scl_level;
    logic        sample_stb;
    logic        change_stb;
    logic        start_hold_done;
    logic        bus_free_done;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string ctx = "";

    always #4 clk = ~clk;

    always @(negedge clk) tick <= tick_mode ? ~tick : 1'b1;

    scl_timing_gen u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick            (tick),
        .cfg_word0       (w0),
        .cfg_word1       (w1),
        .cfg_word2       (w2),
        .start_req       (start_req),
        .stop_req        (stop_req),
        .stretch_req     (stretch_req),
        .scl_level       (scl_level),
        .sample_stb      (sample_stb),
        .change_stb      (change_stb),
        .start_hold_done (start_hold_done),
        .bus_free_done   (bus_free_done)
    );

    function automatic int eff_phase(input int raw);
        return raw % 1024;
    endfunction

    function automatic int min_one(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic step(input bit es, input bit esm, input bit ech, input bit ehd,
                        input bit ebf, input string tag);
        @(negedge clk);
        n_vec++;
        if ({scl_level, sample_stb, change_stb, start_hold_done, bus_free_done} !=
            {es, esm, ech, ehd, ebf}) begin
            n_bad++;
            $display("FAIL %s %s: scl/smp/chg/hold/free got %b%b%b%b%b exp %b%b%b%b%b at %0t",
                     ctx, tag, scl_level, sample_stb, change_stb, start_hold_done,
                     bus_free_done, es, esm, ech, ehd, ebf, $time);
        end
    endtask

    task automatic chk_int(input int got, input int exp, input string tag);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d exp %0d", tag, got, exp);
        end
    endtask

    // One full frame: START hold, nbits bit periods, bus-free, idle.
    task automatic run_frame(input int lead_raw, input int lo_raw, input int xo,
                             input int hi_raw, input int ro, input int bf_raw,
                             input int nbits, input int sbit, input int slen,
                             input bit noise);
        int lh, le, he, bh;
        bit last;
        lh = min_one(lead_raw);
        le = eff_phase(lo_raw) + 2;
        he = eff_phase(hi_raw) + 7;
        bh = min_one(bf_raw);
        w0 = {hi_raw[15:0], ro[15:0]};
        w1 = {lo_raw[15:0], xo[15:0]};
        w2 = {bf_raw[15:0], lead_raw[15:0]};
        @(negedge clk);
        start_req = 1'b1;
        for (int k = 0; k < lh; k++) begin
            step(1, 0, 0, 0, 0, "R8 R2 start hold");
            if (k == 0) start_req = 1'b0;
        end
        for (int b = 0; b < nbits; b++) begin
            last = (b == nbits - 1);
            for (int i = 0; i < le; i++) begin
                step(0, 0, (i == xo), (b == 0 && i == 0), 0, "R3 R6 R2 low phase");
                if (i == 0) begin
                    stop_req    = last;
                    stretch_req = (b == sbit);
                    start_req   = noise && !last;
                end
            end
            for (int j = 0; j < he; j++) begin
                step(1, (j == ro), 0, 0, 0, "R4 R7 R12 high phase");
            end
            if (b == sbit && !last) begin
                for (int s = 0; s < slen; s++) begin
                    step(0, 0, 0, 0, 0, "R10 stretch hold");
                    if (s == slen - 1) stretch_req = 1'b0;
                end
            end
        end
        for (int k = 0; k < bh; k++) begin
            step(1, 0, 0, 0, 0, "R9 R10 bus free");
            start_req = noise && (k < bh - 1);
        end
        step(1, 0, 0, 0, 1, "R9 bus free done");
        stop_req    = 1'b0;
        stretch_req = 1'b0;
        start_req   = 1'b0;
        step(1, 0, 0, 0, 0, "R12 idle after frame");
    endtask

    task automatic tick_run();
        int guard, nlow, nhigh, nchg, nsmp;
        ctx = "R11";
        tick_mode = 1'b1;
        w0 = {16'd2, 16'd0};
        w1 = {16'd3, 16'd1};
        w2 = {16'd1, 16'd1};
        @(negedge clk);
        start_req   = 1'b1;
        stretch_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        guard = 0;
        while (scl_level && guard < 100) begin @(negedge clk); guard++; end
        nlow = 0; nchg = 0;
        while (!scl_level && guard < 200) begin
            nlow++; nchg += change_stb; @(negedge clk); guard++;
        end
        nhigh = 0; nsmp = 0;
        while (scl_level && guard < 300) begin
            nhigh++; nsmp += sample_stb; @(negedge clk); guard++;
        end
        chk_int(nlow, 10, "R11 low cycles at half tick rate");
        chk_int(nhigh, 18, "R11 high cycles at half tick rate");
        chk_int(nchg, 1, "R11 R6 change strobes per low phase");
        chk_int(nsmp, 1, "R11 R7 sample strobes per high phase");
        stop_req    = 1'b1;
        stretch_req = 1'b0;
        while (!bus_free_done && guard < 400) begin @(negedge clk); guard++; end
        chk_int(int'(bus_free_done), 1, "R11 R9 frame ends at half tick rate");
        stop_req  = 1'b0;
        tick_mode = 1'b0;
        repeat (3) @(negedge clk);
        ctx = "";
    endtask

    initial begin
        int lo, hi, xo, ro, nb, sb;
        void'($urandom(32'd4242));
        for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        step(1, 0, 0, 0, 0, "R1 after reset");
        // R12: bit-period requests in idle are ignored
        stop_req = 1'b1; stretch_req = 1'b1;
        for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, "R12 idle requests ignored");
        stop_req = 1'b0; stretch_req = 1'b0;
        // directed corners
        run_frame(0, 0, 0, 0, 0, 0, 1, -1, 0, 1'b0);      // minimum counts
        run_frame(3, 2, 3, 1, 7, 2, 2, -1, 0, 1'b0);      // offsets at last tick
        run_frame(2, 2, 4, 1, 8, 2, 2, -1, 0, 1'b0);      // offsets past end: no strobe
        run_frame(1, 3, 1, 2, 2, 1, 3, 0, 4, 1'b0);       // R10 stretch mid frame
        run_frame(1, 3, 1, 2, 2, 3, 2, 1, 3, 1'b0);       // R10 stop beats stretch
        run_frame(2, 4, 2, 3, 5, 3, 3, 1, 2, 1'b1);       // R12 start_req noise
        ctx = "R5";
        run_frame(1, 16'h0403, 2, 16'hFC02, 3, 1, 2, -1, 0, 1'b0);
        ctx = "";
        tick_run();
        // constrained random frames
        for (int f = 0; f < 40; f++) begin
            lo = $urandom_range(0, 12);
            hi = $urandom_range(0, 12);
            xo = $urandom_range(0, lo + 3);
            ro = $urandom_range(0, hi + 8);
            nb = $urandom_range(1, 4);
            sb = ($urandom_range(0, 2) == 0) ? -1 : $urandom_range(0, nb - 1);
            run_frame($urandom_range(0, 6), lo, xo, hi, ro, $urandom_range(0, 6),
                      nb, sb, $urandom_range(1, 5), $urandom_range(0, 1) == 1);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hung exp complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule